// File: doc/BRIEF.md
# Clear-on-read interrupt status unit

This block gathers single-cycle event pulses from a serial link controller into an 8-bit interrupt status register. Four positions carry events: a loop-back or PRBS status change, a receive FIFO overflow, an all-sent indication and a transmit underrun. A mask register selects which latched events drive the active-low interrupt line. A global visibility control decides what happens to masked events. When it is off, masked events are dropped. When it is on, they latch into the status register but never reach the interrupt line.

A processor read of the status register returns the contents on the next cycle and clears the register in the same cycle. A transmit underrun also sets a transmitter lockout. The lockout keeps the transmitter and its FIFO disabled until the status register is read. The event sources, the FIFOs and the framing logic are not part of this block. They appear only as input pulses and level inputs.

Top module: `irq_status_unit`

## Requirements
- R1: Event bit positions are: bit 7 link/PRBS status change, bit 6 receive overflow, bit 5 all sent, bit 4 transmit underrun. An unmasked event pulse sets its bit, and the bit stays set until a read.
- R2: A cycle with `stat_rd` high loads the current status into `stat_rdata` at that clock edge and clears every status bit at the same edge.
- R3: If an event pulse and `stat_rd` fall in the same cycle, `stat_rdata` shows the old status and the new event stays latched afterwards.
- R4: With `vis_all` low, an event whose mask bit is 1 is discarded and does not latch.
- R5: With `vis_all` high, an event latches whatever its mask bit is.
- R6: `irq_n` is 0 exactly when some status bit is 1 while its mask bit is 0. It follows the status and mask registers at the same clock edge, so a masked latched bit never drives it low.
- R7: The all-sent bit latches only when `last_bit_sent` pulses while `txf_empty` and `hdlc_mode` are both high.
- R8: A transmit underrun pulse sets `tx_lock` whatever the mask and visibility settings are. A status read clears `tx_lock`, except when an underrun arrives in the same cycle, in which case `tx_lock` stays 1.
- R9: Status bits 3 to 0 are reserved and always read as 0.
- R10: Synchronous reset clears the status register, `tx_lock` and `stat_rdata`, sets every mask bit to 1 and drives `irq_n` to 1.
- R11: A mask write takes effect at its clock edge. Events in the same cycle are qualified by the mask that was in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_link_chg | input | 1 | Loop-back/PRBS status change pulse |
| ev_rx_ovf | input | 1 | Receive FIFO overflow pulse |
| last_bit_sent | input | 1 | Last bit of the current frame has left the line |
| txf_empty | input | 1 | Transmit FIFO empty level |
| hdlc_mode | input | 1 | Transmitter is in HDLC mode |
| ev_tx_unr | input | 1 | Transmit underrun pulse |
| vis_all | input | 1 | Latch masked events as well |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write data (1 = masked) |
| stat_rd | input | 1 | Status read strobe (clear on read) |
| stat_rdata | output | 8 | Status value captured by the last read |
| irq_n | output | 1 | Active-low interrupt |
| tx_lock | output | 1 | Transmitter/FIFO disable lockout |

## Verification
The hardest situation to reach is an event that coincides with a clearing read. That is when the read data, the surviving status bit and the lockout must each take a different side of the race. The stimulus sets up this collision directly, including an underrun during a read with the lockout already set. It also sets up a mask write in the same cycle as an event, and latching under visibility mode with every bit masked. After these directed cases, a long random phase drives pulses, reads, mask writes and visibility changes together, so that such coincidences recur. A behavioural model checks the outputs on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int STAT_W   = 8;
  parameter int BIT_LINK = 7;
  parameter int BIT_ROVF = 6;
  parameter int BIT_ALLS = 5;
  parameter int BIT_TUNR = 4;
  parameter int RSVD_TOP = 3;
endpackage

// File: rtl/irq_event_qual.sv
module irq_event_qual
  import irq_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         ev_link_chg,
  input  logic         ev_rx_ovf,
  input  logic         last_bit_sent,
  input  logic         txf_empty,
  input  logic         hdlc_mode,
  input  logic         ev_tx_unr,
  input  logic         vis_all,
  input  logic [W-1:0] mask_q,
  output logic [W-1:0] set_vec
);
  logic [W-1:0] raw_vec;

  always_comb begin
    raw_vec = '0;
    raw_vec[BIT_LINK] = ev_link_chg;
    raw_vec[BIT_ROVF] = ev_rx_ovf;
    raw_vec[BIT_ALLS] = last_bit_sent & txf_empty & hdlc_mode;
    raw_vec[BIT_TUNR] = ev_tx_unr;
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_qual
      if (i <= RSVD_TOP) begin : g_rsvd
        assign set_vec[i] = 1'b0;
      end else begin : g_live
        assign set_vec[i] = raw_vec[i] & (vis_all | ~mask_q[i]);
      end
    end
  endgenerate
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
  import irq_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         stat_rd,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] stat_d,
  output logic [W-1:0] stat_rdata
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign stat_d[i] = set_vec[i] | (stat_q[i] & ~stat_rd);
      always_ff @(posedge clk) begin
        if (rst) stat_q[i] <= 1'b0;
        else     stat_q[i] <= stat_d[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          stat_rdata <= '0;
    else if (stat_rd) stat_rdata <= stat_q;
  end

  assert_read_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && set_vec == '0) |=> (stat_q == '0));
  assert_read_data_R2: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (stat_rdata == $past(stat_q)));
  assert_event_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/irq_mask_out.sv
module irq_mask_out
  import irq_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_wr,
  input  logic [W-1:0] mask_wdata,
  input  logic [W-1:0] stat_d,
  output logic [W-1:0] mask_q,
  output logic         irq_n
);
  logic [W-1:0] mask_d;
  assign mask_d = mask_wr ? mask_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      irq_n  <= 1'b1;
    end else begin
      mask_q <= mask_d;
      irq_n  <= ~|(stat_d & ~mask_d);
    end
  end
endmodule

// File: rtl/irq_tx_lock.sv
module irq_tx_lock (
  input  logic clk,
  input  logic rst,
  input  logic ev_tx_unr,
  input  logic stat_rd,
  output logic tx_lock
);
  always_ff @(posedge clk) begin
    if (rst)            tx_lock <= 1'b0;
    else if (ev_tx_unr) tx_lock <= 1'b1;
    else if (stat_rd)   tx_lock <= 1'b0;
  end

  assert_lock_sets_R8: assert property (@(posedge clk) disable iff (rst)
    ev_tx_unr |=> tx_lock);
  assert_lock_release_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !ev_tx_unr) |=> !tx_lock);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ev_link_chg,
  input  logic         ev_rx_ovf,
  input  logic         last_bit_sent,
  input  logic         txf_empty,
  input  logic         hdlc_mode,
  input  logic         ev_tx_unr,
  input  logic         vis_all,
  input  logic         mask_wr,
  input  logic [W-1:0] mask_wdata,
  input  logic         stat_rd,
  output logic [W-1:0] stat_rdata,
  output logic         irq_n,
  output logic         tx_lock
);
  logic [W-1:0] mask_q;
  logic [W-1:0] set_vec;
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;

  irq_event_qual #(.W(W)) u_qual (
    .ev_link_chg  (ev_link_chg),
    .ev_rx_ovf    (ev_rx_ovf),
    .last_bit_sent(last_bit_sent),
    .txf_empty    (txf_empty),
    .hdlc_mode    (hdlc_mode),
    .ev_tx_unr    (ev_tx_unr),
    .vis_all      (vis_all),
    .mask_q       (mask_q),
    .set_vec      (set_vec)
  );

  irq_stat_reg #(.W(W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (set_vec),
    .stat_rd   (stat_rd),
    .stat_q    (stat_q),
    .stat_d    (stat_d),
    .stat_rdata(stat_rdata)
  );

  irq_mask_out #(.W(W)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .mask_wr   (mask_wr),
    .mask_wdata(mask_wdata),
    .stat_d    (stat_d),
    .mask_q    (mask_q),
    .irq_n     (irq_n)
  );

  irq_tx_lock u_lock (
    .clk      (clk),
    .rst      (rst),
    .ev_tx_unr(ev_tx_unr),
    .stat_rd  (stat_rd),
    .tx_lock  (tx_lock)
  );

  assert_irq_matches_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == ((stat_q & ~mask_q) == '0)));
  assert_vis_off_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (!vis_all && !mask_wr && !stat_rd && ev_rx_ovf && mask_q[BIT_ROVF] && !stat_q[BIT_ROVF])
      |=> !stat_q[BIT_ROVF]);
  assert_rsvd_read_R9: assert property (@(posedge clk) disable iff (rst)
    $past(stat_rd) |-> (stat_rdata[RSVD_TOP:0] == '0));
endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
  logic clk = 1'b0;
  logic rst;
  logic ev_link_chg, ev_rx_ovf, last_bit_sent, txf_empty, hdlc_mode, ev_tx_unr;
  logic vis_all, mask_wr, stat_rd;
  logic [7:0] mask_wdata;
  logic [7:0] stat_rdata;
  logic irq_n, tx_lock;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic [7:0] m_stat, m_mask, m_rdata;
  logic m_lock, m_irqn;

  always #10 clk = ~clk;

  irq_status_unit u_dut (
    .clk(clk), .rst(rst), .ev_link_chg(ev_link_chg), .ev_rx_ovf(ev_rx_ovf),
    .last_bit_sent(last_bit_sent), .txf_empty(txf_empty), .hdlc_mode(hdlc_mode),
    .ev_tx_unr(ev_tx_unr), .vis_all(vis_all), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
    .irq_n(irq_n), .tx_lock(tx_lock)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] ev, setv;
    ev = {ev_link_chg, ev_rx_ovf, last_bit_sent & txf_empty & hdlc_mode, ev_tx_unr, 4'b0};
    setv = ev & (vis_all ? 8'hFF : ~m_mask);
    if (rst) begin
      m_stat = 0; m_mask = 8'hFF; m_rdata = 0; m_lock = 0; m_irqn = 1;
    end else begin
      if (stat_rd) begin m_rdata = m_stat; m_stat = setv; end
      else m_stat = m_stat | setv;
      if (ev_tx_unr) m_lock = 1; else if (stat_rd) m_lock = 0;
      if (mask_wr) m_mask = mask_wdata;
      m_irqn = ((m_stat & ~m_mask) == 0);
    end
  endtask

  task automatic clear_inputs();
    ev_link_chg = 0; ev_rx_ovf = 0; last_bit_sent = 0; ev_tx_unr = 0;
    mask_wr = 0; stat_rd = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    cycles++;
    @(negedge clk);
    chk(stat_rdata == m_rdata, "R2 rdata", stat_rdata, m_rdata);
    chk(irq_n == m_irqn, "R6 irq_n", irq_n, m_irqn);
    chk(tx_lock == m_lock, "R8 tx_lock", tx_lock, m_lock);
    clear_inputs();
  endtask

  task automatic read_expect(input logic [7:0] exp, input string req);
    stat_rd = 1;
    tick();
    chk(stat_rdata == exp, req, stat_rdata, exp);
    chk(stat_rdata[3:0] == 0, "R9 reserved zero", stat_rdata, exp & 8'hF0);
  endtask

  task automatic set_mask(input logic [7:0] m);
    mask_wr = 1; mask_wdata = m;
    tick();
  endtask

  initial begin
    while (!done && cycles < 100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    txf_empty = 0; hdlc_mode = 0; vis_all = 0; mask_wdata = 0;
    m_stat = 0; m_mask = 8'hFF; m_rdata = 0; m_lock = 0; m_irqn = 1;
    rst = 1;
    @(negedge clk);
    tick(); tick();
    rst = 0;
    // R10 reset state
    chk(irq_n == 1 && tx_lock == 0 && stat_rdata == 0, "R10 reset outputs", {irq_n, tx_lock, stat_rdata}, 10'h200);
    // R10 mask all ones: unmasked event would show on irq, none should
    ev_rx_ovf = 1; tick();
    chk(irq_n == 1, "R10 mask resets to ones", irq_n, 1);
    read_expect(8'h00, "R10 status reset empty");

    // R1 bit map, one event at a time
    set_mask(8'h00);
    hdlc_mode = 1; txf_empty = 1;
    ev_link_chg = 1; tick();
    chk(irq_n == 0, "R6 irq on unmasked", irq_n, 0);
    read_expect(8'h80, "R1 link bit7");
    chk(irq_n == 1, "R6 irq released after read", irq_n, 1);
    ev_rx_ovf = 1; tick(); read_expect(8'h40, "R1 rx overflow bit6");
    last_bit_sent = 1; tick(); read_expect(8'h20, "R1 all sent bit5");
    ev_tx_unr = 1; tick();
    chk(tx_lock == 1, "R8 lock set", tx_lock, 1);
    read_expect(8'h10, "R1 underrun bit4");
    chk(tx_lock == 0, "R8 lock released", tx_lock, 0);
    ev_link_chg = 1; tick(); ev_rx_ovf = 1; tick(); tick();
    read_expect(8'hC0, "R1 bits held until read");

    // R7 all-sent qualification
    txf_empty = 0; last_bit_sent = 1; tick();
    txf_empty = 1; hdlc_mode = 0; last_bit_sent = 1; tick();
    read_expect(8'h00, "R7 all sent blocked");
    hdlc_mode = 1; last_bit_sent = 1; tick();
    read_expect(8'h20, "R7 all sent qualified");

    // R3 event with read in same cycle
    ev_link_chg = 1; tick();
    ev_rx_ovf = 1; stat_rd = 1; tick();
    chk(stat_rdata == 8'h80, "R3 read returns old", stat_rdata, 8'h80);
    read_expect(8'h40, "R3 new event kept");

    // R4 visibility off, masked dropped
    set_mask(8'hFF); vis_all = 0;
    ev_link_chg = 1; ev_rx_ovf = 1; last_bit_sent = 1; tick();
    read_expect(8'h00, "R4 masked events dropped");

    // R5 visibility on, masked latched, R6 irq stays high
    vis_all = 1;
    ev_link_chg = 1; ev_rx_ovf = 1; last_bit_sent = 1; ev_tx_unr = 1; tick();
    chk(irq_n == 1, "R6 masked latched no irq", irq_n, 1);
    chk(tx_lock == 1, "R8 masked underrun locks", tx_lock, 1);
    // R6 unmasking a latched bit asserts irq at the write edge
    set_mask(8'hBF);
    chk(irq_n == 0, "R6 unmask latched asserts", irq_n, 0);
    // R8 underrun during read keeps lock
    ev_tx_unr = 1; stat_rd = 1; tick();
    chk(stat_rdata == 8'hF0, "R5 masked events latched", stat_rdata, 8'hF0);
    chk(tx_lock == 1, "R8 underrun with read keeps lock", tx_lock, 1);
    read_expect(8'h10, "R8 underrun latched during read");
    chk(tx_lock == 0, "R8 lock released by read", tx_lock, 0);
    vis_all = 0;

    // R11 mask write with event same cycle uses old mask
    set_mask(8'hFF);
    mask_wr = 1; mask_wdata = 8'h00; ev_link_chg = 1; tick();
    chk(irq_n == 1, "R11 event filtered by old mask", irq_n, 1);
    ev_link_chg = 1; tick();
    chk(irq_n == 0, "R11 new mask in force", irq_n, 0);
    read_expect(8'h80, "R11 only later event latched");

    // random phase, model compared every clock
    for (int k = 0; k < 3000; k++) begin
      ev_link_chg   = ($urandom_range(0, 7) == 0);
      ev_rx_ovf     = ($urandom_range(0, 7) == 0);
      last_bit_sent = ($urandom_range(0, 5) == 0);
      txf_empty     = $urandom_range(0, 1);
      hdlc_mode     = ($urandom_range(0, 3) != 0);
      ev_tx_unr     = ($urandom_range(0, 11) == 0);
      stat_rd       = ($urandom_range(0, 5) == 0);
      mask_wr       = ($urandom_range(0, 15) == 0);
      mask_wdata    = 8'($urandom);
      if ($urandom_range(0, 63) == 0) vis_all = ~vis_all;
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule